// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host bus a single data port into a byte-wide packet RAM. Every access reads or writes one, two or four bytes at a remote address held in a register. The address then advances on its own. A remaining-byte count is reduced by the width of each access. When the count runs out, a sticky completion flag is raised. The address wraps inside a ring of 256-byte pages: when it reaches the stop page boundary, it is reloaded with the start page boundary.

Multi-byte accesses are little-endian. Address bit 0 is forced to zero for two- and four-byte accesses. Only two address windows reach the RAM: a small low window and a packet-memory window at the top of the address space. Writes that fall anywhere else are dropped, and reads there return all ones. The RAM port moves one byte per cycle, so the engine raises a busy signal while a multi-byte access is in progress.

The host loads the address, the count and the page limits one byte at a time. It can also issue a remote command strobe, which raises the flag at once if the count is already zero. The flag is cleared by a write-one-to-clear strobe.

Top module: `rdma_port_engine`

## Requirements
- R1: After each access, the remote address becomes its value before the access plus the width in bytes. Bit 0 is not masked in this sum. If the result equals stop_page*256, the address is loaded with start_page*256 instead.
- R2: At the end of an access, a count less than or equal to the width becomes 0 and the flag is set. Otherwise the count is reduced by the width.
- R3: A write requested while the count is 0 is accepted without raising busy. It changes neither RAM, address, count nor flag.
- R4: `acc_size` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. For widths above 1, the base address has bit 0 cleared. Byte k of the data goes to or comes from base+k, and occupies `acc_rdata`/`acc_wdata` bits [8k+7:8k]. Unused upper read bits are 0.
- R5: An access whose base address is neither below LOW_WIN nor inside [PMEM_START, MEM_SIZE) never asserts `ram_we`.
- R6: A read from an invalid base returns 0xFF, 0xFFFF or 0xFFFFFFFF for widths 1, 2 and 4 respectively.
- R7: A `cmd_remote` pulse while the count is 0 sets the flag on that clock edge.
- R8: The flag stays set until `irq_clr`. If the flag is set and cleared on the same edge, the set wins.
- R9: An accepted access of N bytes holds `busy` high for exactly N cycles. `acc_done` pulses for one cycle as busy falls, and read data is valid in that cycle.
- R10: `reg_sel` chooses the target of a register write: 0 address low byte, 1 address high byte, 2 count low byte, 3 count high byte, 4 start page, 5 stop page. A byte write leaves the other byte unchanged. Register writes are ignored while busy.
- R11: After reset, the address, count, pages and flag are 0, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| cmd_remote | input | 1 | Remote read/write command strobe |
| irq_clr | input | 1 | Clear the completion flag |
| acc_req | input | 1 | Data port access request, sampled while not busy |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | One-cycle end-of-access pulse |
| acc_rdata | output | 32 | Read data |
| rem_addr | output | 16 | Current remote address |
| rem_count | output | 16 | Remaining byte count |
| dma_flag | output | 1 | Sticky remote-DMA-complete flag |
| ram_addr | output | 10 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, combinational from ram_addr |

## Verification
The flag has three sources that can act on the same edge: exhaustion at the end of an access, a remote command at zero count, and the host clear. The bench provokes the collisions directly. It holds `irq_clr` on the very edge where a one-byte read drains the count to zero, and it pulses `cmd_remote` and `irq_clr` together. In both cases the flag must read as set afterwards. A register write issued during a busy access lands on the same edge range as the engine's own address update, and it must leave no trace.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int unsigned RDP_AW = 16;
    localparam int unsigned RDP_DW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        SEL_ADDR_LO = 3'd0,
        SEL_ADDR_HI = 3'd1,
        SEL_CNT_LO  = 3'd2,
        SEL_CNT_HI  = 3'd3,
        SEL_PG_LO   = 3'd4,
        SEL_PG_HI   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [RDP_AW-1:0] base;
        logic [2:0]        nbytes;
        logic              wr;
        logic              ok;
        logic [RDP_DW-1:0] wdata;
    } xfer_t;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic addr_in_window(input logic [31:0] a,
                                            input int unsigned low_win,
                                            input int unsigned pstart,
                                            input int unsigned msize);
        return (a < low_win) || ((a >= pstart) && (a < msize));
    endfunction
endpackage

// File: rtl/rdp_regs.sv
module rdp_regs
    import rdp_pkg::*;
#(
    parameter int unsigned AW = RDP_AW,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [7:0]    reg_wdata,
    input  logic          hold,
    input  logic          fin,
    input  logic [2:0]    step,
    input  logic          cmd_remote,
    input  logic          flag_clr,
    output logic [AW-1:0] rem_addr,
    output logic [AW-1:0] rem_cnt,
    output logic          flag
);
    localparam int unsigned OW = AW - PW;

    logic [PW-1:0] pg_start, pg_stop;
    logic [AW-1:0] ring_lo, ring_hi, addr_sum, addr_next, step_w;
    logic          exhaust, flag_set;

    assign ring_lo   = {pg_start, {OW{1'b0}}};
    assign ring_hi   = {pg_stop,  {OW{1'b0}}};
    assign step_w    = AW'(step);
    assign addr_sum  = rem_addr + step_w;
    assign addr_next = (addr_sum == ring_hi) ? ring_lo : addr_sum;
    assign exhaust   = (rem_cnt <= step_w);
    assign flag_set  = (fin && exhaust) || (cmd_remote && (rem_cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_addr <= '0;
            rem_cnt  <= '0;
            pg_start <= '0;
            pg_stop  <= '0;
        end else if (fin) begin
            rem_addr <= addr_next;
            rem_cnt  <= exhaust ? '0 : (rem_cnt - step_w);
        end else if (reg_wr && !hold) begin
            case (reg_sel_e'(reg_sel))
                SEL_ADDR_LO: rem_addr[7:0]    <= reg_wdata;
                SEL_ADDR_HI: rem_addr[AW-1:8] <= reg_wdata[AW-9:0];
                SEL_CNT_LO:  rem_cnt[7:0]     <= reg_wdata;
                SEL_CNT_HI:  rem_cnt[AW-1:8]  <= reg_wdata[AW-9:0];
                SEL_PG_LO:   pg_start         <= reg_wdata[PW-1:0];
                SEL_PG_HI:   pg_stop          <= reg_wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r1_addr_advance: assert property (@(posedge clk) disable iff (rst)
        fin |=> (rem_addr == AW'($past(rem_addr) + AW'($past(step)))) || (rem_addr == ring_lo));

    a_r2_exhaust_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (fin && (rem_cnt <= AW'(step))) |=> (flag && (rem_cnt == '0)));

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
        fin |=> (rem_cnt <= $past(rem_cnt)));

    a_r7_cmd_zero_count: assert property (@(posedge clk) disable iff (rst)
        (cmd_remote && (rem_cnt == '0)) |=> flag);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && fin && (rem_cnt <= AW'(step))) |=> flag);

    a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (hold && !fin) |=> ($stable(rem_addr) && $stable(rem_cnt)));
endmodule

// File: rtl/rdp_seq.sv
module rdp_seq
    import rdp_pkg::*;
#(
    parameter int unsigned AW         = RDP_AW,
    parameter int unsigned DW         = RDP_DW,
    parameter int unsigned RAW        = 10,
    parameter int unsigned LOW_WIN    = 32,
    parameter int unsigned PMEM_START = 512,
    parameter int unsigned MEM_SIZE   = 1024
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_req,
    input  logic           acc_write,
    input  logic [1:0]     acc_size,
    input  logic [DW-1:0]  acc_wdata,
    input  logic [AW-1:0]  rem_addr,
    input  logic           cnt_zero,
    input  logic [7:0]     ram_rdata,
    output logic           busy,
    output logic           fin,
    output logic [2:0]     step,
    output logic [DW-1:0]  acc_rdata,
    output logic           acc_done,
    output logic [RAW-1:0] ram_addr,
    output logic           ram_we,
    output logic [7:0]     ram_wdata
);
    seq_state_e    state;
    xfer_t         xf, xf_new;
    logic [1:0]    idx;
    logic [DW-1:0] rbuf, merged;
    logic [7:0]    byte_in;
    logic          accept, last;
    logic [2:0]    nb_req;
    logic [AW-1:0] base_req, cur_addr;

    assign nb_req   = size_to_bytes(acc_size);
    assign base_req = (nb_req == 3'd1) ? rem_addr : {rem_addr[AW-1:1], 1'b0};
    assign accept   = (state == ST_IDLE) && acc_req && !(acc_write && cnt_zero);

    always_comb begin
        xf_new.base   = base_req;
        xf_new.nbytes = nb_req;
        xf_new.wr     = acc_write;
        xf_new.ok     = addr_in_window(32'(base_req), LOW_WIN, PMEM_START, MEM_SIZE);
        xf_new.wdata  = acc_wdata;
    end

    assign busy      = (state == ST_XFER);
    assign last      = ({1'b0, idx} == (xf.nbytes - 3'd1));
    assign fin       = busy && last;
    assign step      = xf.nbytes;
    assign cur_addr  = xf.base + AW'(idx);
    assign ram_addr  = cur_addr[RAW-1:0];
    assign ram_we    = busy && xf.wr && xf.ok;
    assign ram_wdata = xf.wdata[{idx, 3'b000} +: 8];
    assign byte_in   = xf.ok ? ram_rdata : 8'hFF;

    always_comb begin
        merged = rbuf;
        merged[{idx, 3'b000} +: 8] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            xf        <= '0;
            idx       <= '0;
            rbuf      <= '0;
            acc_rdata <= '0;
            acc_done  <= 1'b0;
        end else begin
            acc_done <= fin;
            if (accept) begin
                state <= ST_XFER;
                xf    <= xf_new;
                idx   <= '0;
                rbuf  <= '0;
            end else if (busy) begin
                rbuf <= merged;
                idx  <= idx + 2'd1;
                if (last) begin
                    state <= ST_IDLE;
                    if (!xf.wr) acc_rdata <= merged;
                end
            end
        end
    end

    a_r3_zero_count_write: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc_req && acc_write && cnt_zero) |=> !busy);

    a_r4_even_base: assert property (@(posedge clk) disable iff (rst)
        (busy && (xf.nbytes != 3'd1)) |-> (xf.base[0] == 1'b0));

    a_r5_we_only_in_write: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (busy && xf.wr));

    a_r9_index_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({1'b0, idx} < xf.nbytes));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        fin |=> (acc_done && !busy));
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdp_pkg::*;
#(
    parameter int unsigned AW         = RDP_AW,
    parameter int unsigned DW         = RDP_DW,
    parameter int unsigned PW         = 8,
    parameter int unsigned LOW_WIN    = 32,
    parameter int unsigned PMEM_START = 512,
    parameter int unsigned MEM_SIZE   = 1024,
    localparam int unsigned RAW       = $clog2(MEM_SIZE)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [2:0]     reg_sel,
    input  logic [7:0]     reg_wdata,
    input  logic           cmd_remote,
    input  logic           irq_clr,
    input  logic           acc_req,
    input  logic           acc_write,
    input  logic [1:0]     acc_size,
    input  logic [DW-1:0]  acc_wdata,
    output logic           acc_busy,
    output logic           acc_done,
    output logic [DW-1:0]  acc_rdata,
    output logic [AW-1:0]  rem_addr,
    output logic [AW-1:0]  rem_count,
    output logic           dma_flag,
    output logic [RAW-1:0] ram_addr,
    output logic           ram_we,
    output logic [7:0]     ram_wdata,
    input  logic [7:0]     ram_rdata
);
    logic       fin;
    logic [2:0] step;

    rdp_regs #(.AW(AW), .PW(PW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .hold       (acc_busy),
        .fin        (fin),
        .step       (step),
        .cmd_remote (cmd_remote),
        .flag_clr   (irq_clr),
        .rem_addr   (rem_addr),
        .rem_cnt    (rem_count),
        .flag       (dma_flag)
    );

    rdp_seq #(
        .AW(AW), .DW(DW), .RAW(RAW), .LOW_WIN(LOW_WIN),
        .PMEM_START(PMEM_START), .MEM_SIZE(MEM_SIZE)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc_req   (acc_req),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .rem_addr  (rem_addr),
        .cnt_zero  (rem_count == '0),
        .ram_rdata (ram_rdata),
        .busy      (acc_busy),
        .fin       (fin),
        .step      (step),
        .acc_rdata (acc_rdata),
        .acc_done  (acc_done),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata)
    );

    a_r9_no_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        acc_done |-> !acc_busy);
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;
    localparam int MSZ = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, cmd_remote = 0, irq_clr = 0, acc_req = 0, acc_write = 0;
    logic [2:0]  reg_sel = 0;
    logic [7:0]  reg_wdata = 0;
    logic [1:0]  acc_size = 0;
    logic [31:0] acc_wdata = 0;
    logic        acc_busy, acc_done, dma_flag, ram_we;
    logic [31:0] acc_rdata;
    logic [15:0] rem_addr, rem_count;
    logic [9:0]  ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;

    logic [7:0] ram     [0:MSZ-1];
    logic [7:0] exp_mem [0:MSZ-1];

    int errors = 0, checks = 0, cycles = 0, we_seen = 0;

    always #2 clk = ~clk;

    rdma_port_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cmd_remote(cmd_remote), .irq_clr(irq_clr), .acc_req(acc_req), .acc_write(acc_write),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_busy(acc_busy), .acc_done(acc_done),
        .acc_rdata(acc_rdata), .rem_addr(rem_addr), .rem_count(rem_count), .dma_flag(dma_flag),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    assign ram_rdata = ram[ram_addr];
    always @(posedge clk) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        if (ram_we) we_seen++;
    end

    // behavioural reference model
    int          m_busy = 0, m_n = 0;
    logic [15:0] m_addr = 0, m_cnt = 0;
    logic [7:0]  m_sp = 0, m_ep = 0;
    logic        m_flag = 0, m_done = 0, m_wr = 0;
    logic [31:0] m_rdata = 0, m_pend = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_addr = 0; m_cnt = 0; m_sp = 0; m_ep = 0;
            m_flag = 0; m_done = 0; m_rdata = 0;
        end else begin
            automatic bit          set = 0;
            automatic logic [15:0] c0 = m_cnt;
            m_done = 0;
            if (cmd_remote && c0 == 0) set = 1;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    automatic logic [15:0] nx = m_addr + 16'(m_n);
                    if (nx == {m_ep, 8'h00}) nx = {m_sp, 8'h00};
                    m_addr = nx;
                    if (c0 <= 16'(m_n)) begin m_cnt = 0; set = 1; end
                    else m_cnt = c0 - 16'(m_n);
                    m_done = 1;
                    if (!m_wr) m_rdata = m_pend;
                end
            end else begin
                if (acc_req && !(acc_write && c0 == 0)) begin
                    automatic int  b;
                    automatic bit  ok;
                    m_n = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
                    b = (m_n > 1) ? (int'(m_addr) & ~1) : int'(m_addr);
                    ok = (b < 32) || (b >= 512 && b < MSZ);
                    m_pend = 0;
                    m_wr = acc_write;
                    for (int k = 0; k < m_n; k++) begin
                        automatic int a = (b + k) % MSZ;
                        if (acc_write) begin
                            if (ok) exp_mem[a] = acc_wdata[8*k +: 8];
                        end else begin
                            m_pend[8*k +: 8] = ok ? exp_mem[a] : 8'hFF;
                        end
                    end
                    m_busy = m_n;
                end
                if (reg_wr) begin
                    case (reg_sel)
                        3'd0: m_addr[7:0]  = reg_wdata;
                        3'd1: m_addr[15:8] = reg_wdata;
                        3'd2: m_cnt[7:0]   = reg_wdata;
                        3'd3: m_cnt[15:8]  = reg_wdata;
                        3'd4: m_sp         = reg_wdata;
                        3'd5: m_ep         = reg_wdata;
                        default: ;
                    endcase
                end
            end
            if (set) m_flag = 1;
            else if (irq_clr) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(acc_busy == (m_busy > 0), "R9 busy", 32'(acc_busy), 32'(m_busy > 0));
            chk(acc_done == m_done, "R9 done", 32'(acc_done), 32'(m_done));
            chk(rem_addr == m_addr, "R1 address", 32'(rem_addr), 32'(m_addr));
            chk(rem_count == m_cnt, "R2 count", 32'(rem_count), 32'(m_cnt));
            chk(dma_flag == m_flag, "R8 flag", 32'(dma_flag), 32'(m_flag));
            if (m_done && !m_wr) chk(acc_rdata == m_rdata, "R4 read data", acc_rdata, m_rdata);
        end
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #80000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wreg(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic set_ac(input logic [15:0] a, input logic [15:0] c);
        wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
        wreg(3'd2, c[7:0]); wreg(3'd3, c[15:8]);
    endtask

    task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk); acc_req = 1; acc_write = w; acc_size = sz; acc_wdata = d;
        @(negedge clk); acc_req = 0;
        while (acc_busy) @(negedge clk);
        rd = acc_rdata;
    endtask

    task automatic pulse_cmd_clr(input bit c, input bit k);
        @(negedge clk); cmd_remote = c; irq_clr = k;
        @(negedge clk); cmd_remote = 0; irq_clr = 0;
    endtask

    initial begin
        logic [31:0] rd;
        int we0;
        for (int i = 0; i < MSZ; i++) begin
            ram[i] = 8'((i * 7 + 3) & 255);
            exp_mem[i] = ram[i];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(rem_addr == 0 && rem_count == 0 && !dma_flag && !acc_busy && !acc_done,
            "R11 reset state", {rem_addr, rem_count}, 32'h0);

        // R10 byte loads keep other byte
        wreg(3'd0, 8'h34); wreg(3'd1, 8'h12); wreg(3'd1, 8'h02);
        chk(rem_addr == 16'h0234, "R10 byte load", 32'(rem_addr), 32'h0234);

        wreg(3'd4, 8'h02); wreg(3'd5, 8'h03);
        set_ac(16'h0200, 16'h000A);
        access(1, 2'd2, 32'h11223344, rd);
        chk(rem_addr == 16'h0204 && rem_count == 16'd6, "R2 4B write step", {rem_addr, rem_count}, 32'h02040006);
        wreg(3'd0, 8'h05);
        access(1, 2'd1, 32'h0000BEEF, rd);
        chk(rem_addr == 16'h0207, "R1 advance from unmasked address", 32'(rem_addr), 32'h0207);
        access(1, 2'd2, 32'hA5A5A5A5, rd);
        chk(rem_count == 0 && dma_flag, "R2 exhaust sets flag", {15'b0, dma_flag, rem_count}, 32'h00010000);
        we0 = we_seen;
        access(1, 2'd0, 32'h77, rd);
        chk(rem_addr == 16'h020B && we_seen == we0, "R3 zero count write ignored", 32'(rem_addr), 32'h020B);

        pulse_cmd_clr(0, 1);
        chk(!dma_flag, "R8 clear", 32'(dma_flag), 0);
        pulse_cmd_clr(1, 0);
        chk(dma_flag, "R7 command at zero count", 32'(dma_flag), 1);
        pulse_cmd_clr(1, 1);
        chk(dma_flag, "R8 set beats clear", 32'(dma_flag), 1);
        pulse_cmd_clr(0, 1);

        set_ac(16'h0200, 16'h0020);
        access(0, 2'd2, 0, rd);
        chk(rd == 32'h11223344, "R4 little-endian word", rd, 32'h11223344);
        wreg(3'd0, 8'h05);
        access(0, 2'd1, 0, rd);
        chk(rd == 32'h0000BEEF, "R4 half at forced even base", rd, 32'h0000BEEF);
        wreg(3'd0, 8'h0B);
        access(0, 2'd0, 0, rd);
        chk(rd == 32'h00000050, "R3 memory untouched by ignored write", rd, 32'h50);

        set_ac(16'h02FC, 16'h0008);
        access(0, 2'd3, 0, rd);
        chk(rem_addr == 16'h0200, "R1 wrap at stop page", 32'(rem_addr), 32'h0200);

        set_ac(16'h0100, 16'h0010);
        we0 = we_seen;
        access(1, 2'd2, 32'hDEADBEEF, rd);
        chk(we_seen == we0, "R5 invalid write dropped", 32'(we_seen - we0), 0);
        wreg(3'd0, 8'h00);
        access(0, 2'd2, 0, rd);
        chk(rd == 32'hFFFFFFFF, "R6 invalid word", rd, 32'hFFFFFFFF);
        access(0, 2'd1, 0, rd);
        chk(rd == 32'h0000FFFF, "R6 invalid half", rd, 32'h0000FFFF);
        access(0, 2'd0, 0, rd);
        chk(rd == 32'h000000FF, "R6 invalid byte", rd, 32'hFF);

        set_ac(16'h0010, 16'h0010);
        access(1, 2'd1, 32'h1234, rd);
        wreg(3'd0, 8'h10);
        access(0, 2'd1, 0, rd);
        chk(rd == 32'h1234, "R5 low window valid", rd, 32'h1234);
        wreg(3'd0, 8'h20);
        access(0, 2'd0, 0, rd);
        chk(rd == 32'hFF, "R6 just above low window", rd, 32'hFF);

        // R8: clear on the same edge as exhaustion
        pulse_cmd_clr(0, 1);
        set_ac(16'h0210, 16'h0001);
        @(negedge clk); acc_req = 1; acc_write = 0; acc_size = 0;
        @(negedge clk); acc_req = 0; irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        chk(dma_flag && rem_count == 0, "R8 exhaust beats clear", 32'(dma_flag), 1);

        // R10 register write during busy ignored
        set_ac(16'h0220, 16'h0010);
        @(negedge clk); acc_req = 1; acc_size = 2;
        @(negedge clk); acc_req = 0; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h99;
        @(negedge clk); reg_wr = 0;
        while (acc_busy) @(negedge clk);
        chk(rem_addr == 16'h0224, "R10 write ignored while busy", 32'(rem_addr), 32'h0224);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule